// File: doc/BRIEF.md
# Interrupt Source Fan-Out Multiplexer

This block takes a bundle of level-sensitive, active-high interrupt request lines and distributes them to a set of independent output channels. Each source line is visible to every channel. Software chooses which sources each channel listens to by programming a per-channel mask. A channel's output is asserted whenever at least one of its unmasked sources is high. Because any source may be unmasked in more than one channel, a single request can be steered to several interrupt controllers or cores at the same time.

Software reaches the block through a minimal register port: byte address, write strobe, write data, and read data. Each channel owns a 64-byte window. That window holds a read/write mask word and a read-only word that shows the masked source levels. The block keeps no memory of past source activity. An output falls as soon as the enabling condition goes away, and a source that is not masked in any channel is simply not seen.

Top module: `irq_fanout_mux`

## Requirements
- R1: After synchronous reset, every channel mask reads 0 and every `chan_irq` bit is 0.
- R2: The mask word of channel n is at byte address 0x40*n + 0x10, with bit k gating source k. A write there takes effect at the next rising clock edge, and a read returns the last value written, so software can change single bits by read-modify-write.
- R3: Reading byte address 0x40*n + 0x20 returns, in the same cycle, `src_lvl` ANDed with channel n's mask.
- R4: `chan_irq[n]` equals the OR of channel n's masked source bits sampled at the previous rising edge, so there is exactly one register stage between a source or mask and the output.
- R5: A single source that is unmasked in several channels raises all of those channel outputs together.
- R6: Writing 0 to a channel's mask word deasserts that channel's output one edge after the mask clears, even with every source high.
- R7: Writes to a masked-view address (offset 0x20 in a channel window) change no mask and no output.
- R8: Reads of any address other than a mask word or masked view return 0. This covers other offsets in a window and any window at or above channel count. Writes to such addresses change no mask.
- R9: A write to one channel's mask word leaves every other channel's mask unchanged.
- R10: Sources are not latched: when a source falls, the outputs it alone was driving fall one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 32 | Level-sensitive source request lines |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| chan_irq | output | 8 | Registered per-channel interrupt outputs |

## Verification
The hardest case to reach from the ports is a write that lands on an address the decoder must reject while every source is high and several masks are already loaded. This covers a masked-view offset, an address just off a mask word, and a window beyond the last channel. Only in that setup would a decoder slip show up as a change in some mask or output. The stimulus loads distinct masks into several channels, drives all sources high, writes all-ones to each rejected address, then reads every mask word back and checks the outputs. A pseudo-random phase then mixes source patterns and mask writes across channels against a cycle-exact reference model.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

    // Each channel window spans 2**WIN_LG bytes.
    localparam int WIN_LG = 6;

    localparam logic [WIN_LG-1:0] OFS_MASK = 6'h10;
    localparam logic [WIN_LG-1:0] OFS_VIEW = 6'h20;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_MASK = 2'd1,
        RK_VIEW = 2'd2
    } reg_kind_e;

    function automatic reg_kind_e kind_of(logic [WIN_LG-1:0] ofs);
        case (ofs)
            OFS_MASK: return RK_MASK;
            OFS_VIEW: return RK_VIEW;
            default:  return RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irqmux_decode.sv
module irqmux_decode
    import irqmux_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   ch
);
    localparam int WIN_FIELD_W = ADDR_W - WIN_LG;

    logic [WIN_FIELD_W-1:0] win;
    logic                   in_range;

    assign win      = addr[ADDR_W-1:WIN_LG];
    assign in_range = (int'(win) < NUM_CH);
    assign ch       = win[CH_W-1:0];

    always_comb begin
        kind = RK_NONE;
        if (in_range) begin
            kind = kind_of(addr[WIN_LG-1:0]);
        end
    end
endmodule

// File: rtl/irqmux_chan.sv
module irqmux_chan #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] view,
    output logic               irq_q
);
    assign view = src_lvl & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                mask_q <= wr_data;
            end
            irq_q <= |view;
        end
    end

    // R2: a write strobe loads the mask word on the next edge
    a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask_q == $past(wr_data)));

    // R9: without a strobe for this channel the mask holds
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q));

    // R4: output is one stage behind the masked source levels
    a_r4_irq_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_q == |($past(src_lvl) & $past(mask_q))));

    // R10: all sources low means the output drops on the next edge
    a_r10_no_latch: assert property (@(posedge clk) disable iff (rst)
        (src_lvl == '0) |=> !irq_q);
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
    import irqmux_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CH  = 8,
    parameter int ADDR_W  = 12,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic [NUM_CH-1:0]  chan_irq
);
    reg_kind_e                        sel_kind;
    logic [CH_W-1:0]                  sel_ch;
    logic [NUM_CH-1:0]                wr_vec;
    logic [NUM_CH-1:0][NUM_SRC-1:0]   mask_all;
    logic [NUM_CH-1:0][NUM_SRC-1:0]   view_all;

    irqmux_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_dec (
        .addr (reg_addr),
        .kind (sel_kind),
        .ch   (sel_ch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_vec[c] = reg_wr && (sel_kind == RK_MASK) && (sel_ch == CH_W'(c));

        irqmux_chan #(
            .NUM_SRC (NUM_SRC)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .src_lvl (src_lvl),
            .wr_en   (wr_vec[c]),
            .wr_data (reg_wdata),
            .mask_q  (mask_all[c]),
            .view    (view_all[c]),
            .irq_q   (chan_irq[c])
        );
    end

    always_comb begin
        case (sel_kind)
            RK_MASK: reg_rdata = mask_all[sel_ch];
            RK_VIEW: reg_rdata = view_all[sel_ch];
            default: reg_rdata = '0;
        endcase
    end

    // R9: at most one channel mask is written per cycle
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_vec));

    // R7: a write to a masked-view address leaves all masks intact
    a_r7_view_readonly: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel_kind == RK_VIEW) |=> $stable(mask_all));

    // R8: unmapped reads return zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (sel_kind == RK_NONE) |-> (reg_rdata == '0));

    // R3: the masked view never shows a source that is low
    a_r3_view_subset: assert property (@(posedge clk) disable iff (rst)
        (sel_kind == RK_VIEW) |-> ((reg_rdata & ~src_lvl) == '0));
endmodule

// File: tb/sim_irq_fanout_mux.sv
module sim_irq_fanout_mux;
    localparam int NS = 32;
    localparam int NC = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_lvl = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic [NC-1:0] chan_irq;

    always #4 clk = ~clk;

    irq_fanout_mux u0 (
        .clk       (clk),
        .rst       (rst),
        .src_lvl   (src_lvl),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .chan_irq  (chan_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t         sb_q[$];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [NS-1:0] mask_m [NC];
    logic [NC-1:0] irq_m = '0;

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int w;
        w = int'(a[AW-1:6]);
        if (w >= NC) return '0;
        if (a[5:0] == 6'h10) return mask_m[w];
        if (a[5:0] == 6'h20) return src_lvl & mask_m[w];
        return '0;
    endfunction

    task automatic cyc();
        logic [NC-1:0] nx;
        int w;
        @(posedge clk);
        for (int c = 0; c < NC; c++) nx[c] = |(src_lvl & mask_m[c]);
        w = int'(reg_addr[AW-1:6]);
        if (reg_wr && w < NC && reg_addr[5:0] == 6'h10) mask_m[w] = reg_wdata;
        if (rst) begin
            for (int c = 0; c < NC; c++) mask_m[c] = '0;
            nx = '0;
        end
        irq_m = nx;
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        cyc();
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        reg_addr = a;
        sb_q.push_back('{1'b0, model_read(a), req});
        cyc();
    endtask

    task automatic chk_irq(input string req);
        sb_q.push_back('{1'b1, 32'(irq_m), req});
        cyc();
    endtask

    // monitor: pops expected items and compares mid-cycle
    item_t       mon_it;
    logic [31:0] mon_act;
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            mon_it  = sb_q.pop_front();
            mon_act = mon_it.is_irq ? 32'(chan_irq) : reg_rdata;
            n_chk++;
            if (mon_act !== mon_it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", mon_it.req, mon_act, mon_it.exp);
            end
        end
    end

    initial begin
        logic [31:0] lf;
        for (int c = 0; c < NC; c++) mask_m[c] = '0;
        rst = 1'b1;
        repeat (4) cyc();
        rst = 1'b0;

        // R1 reset state
        chk_irq("R1");
        rd(12'h010, "R1");
        rd(12'h1D0, "R1");

        // R3: masked view is zero when mask is clear
        src_lvl = '1;
        rd(12'h020, "R3");
        chk_irq("R1");

        // R2 write/readback, R3 view, R4 output timing
        wr(12'h010, 32'h0000_0005);
        rd(12'h010, "R2");
        src_lvl = 32'h0000_0001;
        rd(12'h020, "R3");
        chk_irq("R4");
        src_lvl = 32'h0000_0004;
        rd(12'h020, "R3");
        chk_irq("R4");

        // R5: one source routed to several channels
        src_lvl = 32'h8000_0000;
        wr(12'h0D0, 32'h8000_0000);
        wr(12'h150, 32'h8000_0001);
        chk_irq("R5");
        chk_irq("R5");
        rd(12'h160, "R5");

        // R9: other channels untouched
        rd(12'h050, "R9");
        rd(12'h010, "R9");
        rd(12'h0D0, "R9");

        // R7 / R8: rejected writes with all sources high
        src_lvl = '1;
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h0E0, 32'hFFFF_FFFF);
        wr(12'h210, 32'hFFFF_FFFF);
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h011, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        for (int c = 0; c < NC; c++) rd(AW'(c * 64 + 16), "R7");
        chk_irq("R7");
        rd(12'h210, "R8");
        rd(12'h220, "R8");
        rd(12'h014, "R8");
        rd(12'h000, "R8");
        rd(12'h03C, "R8");
        rd(12'hFD0, "R8");

        // R10: dropping the sources drops the outputs
        src_lvl = '0;
        cyc();
        chk_irq("R10");
        src_lvl = 32'h8000_0000;
        cyc();
        chk_irq("R10");

        // R6: clearing a mask with all sources high
        src_lvl = '1;
        cyc();
        chk_irq("R6");
        wr(12'h150, 32'h0);
        chk_irq("R6");
        chk_irq("R6");
        rd(12'h150, "R6");

        // R2: read-modify-write on channel 7
        wr(12'h1D0, 32'hFFFF_FFFF);
        rd(12'h1D0, "R2");
        wr(12'h1D0, mask_m[7] & ~32'h0000_0200);
        rd(12'h1D0, "R2");
        wr(12'h1D0, mask_m[7] | 32'h0000_0200);
        rd(12'h1D0, "R2");

        // mixed patterns against the model
        lf = 32'hACE1_2345;
        for (int i = 0; i < 48; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            src_lvl = lf ^ {lf[15:0], lf[31:16]};
            if (i % 3 == 0) wr(AW'((i % NC) * 64 + 16), lf);
            rd(AW'(((i + 3) % NC) * 64 + 32), "R3");
            chk_irq("R4");
        end

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule